// File: doc/BRIEF.md
# Instruction Exception Precheck Unit

This unit sits beside the decode stage of a small CPU with 16-bit instructions. It examines each instruction before that instruction executes and decides whether the instruction must fault instead. It makes three decisions.

- An instruction that may not be placed in a branch delay slot is refused when it is found in one.
- A privileged instruction is refused when the processor is in user mode.
- An instruction that touches the floating-point control or communication registers is refused when floating-point access is switched off.

When a fault is found, the unit produces a one-cycle report. The report carries an exception code and the program counter that the handler must save. A fault in a delay slot saves the address of the branch that owns the slot, which is the current PC minus 2. Any other fault saves the current PC. Vectoring, the register bank switch and the floating-point datapath are handled elsewhere.

The control is a two-state machine. ST_QUIET means no report is driven. ST_RAISE means a report is being driven. The machine moves from either state to ST_RAISE when an accepted instruction faults. It moves to ST_QUIET when the accepted instruction does not fault, or when no instruction is offered. The code and saved-PC registers load only on the transition into ST_RAISE, and they hold their value otherwise.

Top module: `instr_exc_precheck`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, exc_valid is 0 and exc_code and exc_pc are 0.
- R2: An FPU-class instruction accepted with fpu_off=1 outside a delay slot raises code 0x800 with exc_pc equal to its pc.
- R3: An FPU-class instruction accepted with fpu_off=1 inside a delay slot raises code 0x820 with exc_pc equal to its pc minus 2.
- R4: An instruction with slot_forbid=1 accepted inside a delay slot raises code 0x1A0 with exc_pc equal to its pc minus 2.
- R5: An instruction with priv_op=1 accepted with priv_mode=0 (user mode) raises code 0x180 with exc_pc equal to its pc.
- R6: When several faults apply to one instruction, exactly one is reported. The slot fault wins, then the privilege fault, then the FPU fault.
- R7: An opcode is FPU-class when (opcode AND 0xF0FF) equals one of 0x406A, 0x4066, 0x006A, 0x4062, 0x405A, 0x4056, 0x005A or 0x4052. Any other opcode never raises code 0x800 or 0x820.
- R8: The instruction is in a delay slot when bit 0 (plain slot) or bit 1 (conditional slot) of slot_flags is set. Bit 2 (condition taken) and bit 3 (clear pending) have no effect.
- R9: The report for an instruction sampled on a rising edge appears right after that edge and lasts one cycle. A cycle with instr_valid=0 gives no report. While exc_valid is 0, exc_code and exc_pc keep their last values.
- R10: The pc minus 2 value wraps modulo 2^PC_W, so pc=0 saves all ones minus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is offered this cycle |
| opcode | input | 16 | Instruction word |
| pc | input | PC_W | Address of the offered instruction |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| fpu_off | input | 1 | 1 = floating-point access disabled |
| slot_flags | input | 4 | Delay-slot state: bit0 slot, bit1 conditional slot, bit2 taken, bit3 clear pending |
| slot_forbid | input | 1 | Decoder marks the instruction as illegal in a delay slot |
| priv_op | input | 1 | Decoder marks the instruction as privileged |
| exc_valid | output | 1 | One-cycle exception report |
| exc_code | output | 12 | Exception code of the report |
| exc_pc | output | PC_W | PC value to save |

## Verification
The slot-illegal check and the FPU-disable check can both apply to one instruction. This happens when an FPU-class opcode that is also marked slot-forbidden arrives inside a delay slot with floating-point access off. Both candidate codes then save the branch address, so only the code tells which check won. The bench provokes this collision in directed cases and in random mixes that also raise the privilege fault, and expects 0x1A0 every time. Cases with only bits 2 and 3 of the slot flags set are included as well: they must yield the out-of-slot code 0x800 and the unadjusted PC.

// File: rtl/prechk_pkg.sv
package prechk_pkg;
    localparam int OP_W     = 16;
    localparam int CODE_W   = 12;
    localparam int FPU_OP_N = 8;

    localparam logic [OP_W-1:0] OP_REG_MASK = 16'hF0FF;

    // FPU-class opcodes with the register nibble cleared
    localparam logic [FPU_OP_N*OP_W-1:0] FPU_OP_LIST = {
        16'h406A, 16'h4066, 16'h006A, 16'h4062,
        16'h405A, 16'h4056, 16'h005A, 16'h4052
    };

    localparam logic [CODE_W-1:0] CODE_FPU_OFF      = 12'h800;
    localparam logic [CODE_W-1:0] CODE_FPU_OFF_SLOT = 12'h820;
    localparam logic [CODE_W-1:0] CODE_SLOT_ILLEGAL = 12'h1A0;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL      = 12'h180;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_SLOT,
        CAUSE_PRIV,
        CAUSE_FPU
    } cause_e;

    typedef enum logic {
        ST_QUIET,
        ST_RAISE
    } state_e;
endpackage

// File: rtl/prechk_fpu_match.sv
module prechk_fpu_match
    import prechk_pkg::*;
#(
    parameter int N_OPS = FPU_OP_N
) (
    input  logic [OP_W-1:0] opcode,
    output logic            is_fpu
);
    logic [N_OPS-1:0] hit;
    logic [OP_W-1:0]  key;

    assign key = opcode & OP_REG_MASK;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cmp
        assign hit[g] = (key == FPU_OP_LIST[g*OP_W +: OP_W]);
    end

    assign is_fpu = |hit;
endmodule

// File: rtl/prechk_arbiter.sv
module prechk_arbiter
    import prechk_pkg::*;
(
    input  logic   instr_valid,
    input  logic   in_slot,
    input  logic   slot_forbid,
    input  logic   priv_op,
    input  logic   user_mode,
    input  logic   fpu_op,
    input  logic   fpu_off,
    output cause_e cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (instr_valid) begin
            if (slot_forbid && in_slot) begin
                cause = CAUSE_SLOT;
            end else if (priv_op && user_mode) begin
                cause = CAUSE_PRIV;
            end else if (fpu_op && fpu_off) begin
                cause = CAUSE_FPU;
            end
        end
    end
endmodule

// File: rtl/instr_exc_precheck.sv
module instr_exc_precheck
    import prechk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [PC_W-1:0]   pc,
    input  logic              priv_mode,
    input  logic              fpu_off,
    input  logic [3:0]        slot_flags,
    input  logic              slot_forbid,
    input  logic              priv_op,
    output logic              exc_valid,
    output logic [CODE_W-1:0] exc_code,
    output logic [PC_W-1:0]   exc_pc
);
    localparam logic [PC_W-1:0] SLOT_BACK = PC_W'(2);

    state_e            state_q, state_d;
    cause_e            cause;
    logic              in_slot;
    logic              fpu_op;
    logic [CODE_W-1:0] code_d;
    logic [PC_W-1:0]   pc_d;
    logic [1:0]        unused_flags;

    assign in_slot      = slot_flags[0] | slot_flags[1];
    assign unused_flags = slot_flags[3:2];

    prechk_fpu_match #(.N_OPS(FPU_OP_N)) u_match (
        .opcode (opcode),
        .is_fpu (fpu_op)
    );

    prechk_arbiter u_arb (
        .instr_valid (instr_valid),
        .in_slot     (in_slot),
        .slot_forbid (slot_forbid),
        .priv_op     (priv_op),
        .user_mode   (!priv_mode),
        .fpu_op      (fpu_op),
        .fpu_off     (fpu_off),
        .cause       (cause)
    );

    always_comb begin
        code_d = exc_code;
        pc_d   = exc_pc;
        unique case (cause)
            CAUSE_SLOT: begin
                code_d = CODE_SLOT_ILLEGAL;
                pc_d   = pc - SLOT_BACK;
            end
            CAUSE_PRIV: begin
                code_d = CODE_ILLEGAL;
                pc_d   = pc;
            end
            CAUSE_FPU: begin
                code_d = in_slot ? CODE_FPU_OFF_SLOT : CODE_FPU_OFF;
                pc_d   = in_slot ? pc - SLOT_BACK : pc;
            end
            CAUSE_NONE: begin
                code_d = exc_code;
                pc_d   = exc_pc;
            end
        endcase
        state_d = (cause == CAUSE_NONE) ? ST_QUIET : ST_RAISE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_QUIET;
            exc_code <= '0;
            exc_pc   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RAISE) begin
                exc_code <= code_d;
                exc_pc   <= pc_d;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET: exc_valid = 1'b0;
            ST_RAISE: exc_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/prechk_checker.sv
module prechk_checker
    import prechk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [PC_W-1:0]   pc,
    input logic              priv_mode,
    input logic [3:0]        slot_flags,
    input logic              slot_forbid,
    input logic              priv_op,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic [PC_W-1:0]   exc_pc
);
    logic slot_now;
    assign slot_now = slot_flags[0] | slot_flags[1];

    // R4
    slot_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && slot_forbid && slot_now) |=>
            (exc_valid && exc_code == CODE_SLOT_ILLEGAL && exc_pc == $past(pc) - PC_W'(2)));

    // R5
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && priv_op && !priv_mode && !(slot_forbid && slot_now)) |=>
            (exc_valid && exc_code == CODE_ILLEGAL && exc_pc == $past(pc)));

    // R9
    no_instr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !exc_valid);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> ($stable(exc_code) && $stable(exc_pc)));

    // R3
    fpu_slot_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_code == CODE_FPU_OFF_SLOT) |-> (exc_pc == $past(pc) - PC_W'(2)));

    // R6
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code == CODE_FPU_OFF || exc_code == CODE_FPU_OFF_SLOT ||
                       exc_code == CODE_SLOT_ILLEGAL || exc_code == CODE_ILLEGAL));
endmodule

bind instr_exc_precheck prechk_checker #(.PC_W(PC_W)) u_prechk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .pc          (pc),
    .priv_mode   (priv_mode),
    .slot_flags  (slot_flags),
    .slot_forbid (slot_forbid),
    .priv_op     (priv_op),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .exc_pc      (exc_pc)
);

// File: tb/test_instr_exc_precheck.sv
`timescale 1ns/1ps
module test_instr_exc_precheck;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            instr_valid;
    logic [15:0]     opcode;
    logic [PC_W-1:0] pc;
    logic            priv_mode;
    logic            fpu_off;
    logic [3:0]      slot_flags;
    logic            slot_forbid;
    logic            priv_op;
    logic            exc_valid;
    logic [11:0]     exc_code;
    logic [PC_W-1:0] exc_pc;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [11:0]     held_code;
    logic [PC_W-1:0] held_pc;

    always #2 clk = ~clk;

    instr_exc_precheck #(.PC_W(PC_W)) i_instr_exc_precheck (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .opcode (opcode),
        .pc (pc), .priv_mode (priv_mode), .fpu_off (fpu_off), .slot_flags (slot_flags),
        .slot_forbid (slot_forbid), .priv_op (priv_op), .exc_valid (exc_valid),
        .exc_code (exc_code), .exc_pc (exc_pc)
    );

    function automatic bit is_fpu_op(input logic [15:0] op);
        logic [15:0] k = op & 16'hF0FF;
        return k == 16'h406A || k == 16'h4066 || k == 16'h006A || k == 16'h4062 ||
               k == 16'h405A || k == 16'h4056 || k == 16'h005A || k == 16'h4052;
    endfunction

    function automatic logic [15:0] fpu_pick(input int idx, input logic [3:0] rn);
        logic [15:0] base;
        case (idx % 8)
            0: base = 16'h406A; 1: base = 16'h4066; 2: base = 16'h006A; 3: base = 16'h4062;
            4: base = 16'h405A; 5: base = 16'h4056; 6: base = 16'h005A; default: base = 16'h4052;
        endcase
        return base | {4'h0, rn, 8'h00};
    endfunction

    task automatic check(input string req, input bit got_ok, input string what,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (!got_ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at negedge, result sampled at following negedge
    task automatic apply(input string req, input bit v, input logic [15:0] op,
                         input logic [PC_W-1:0] p, input bit md, input bit fd,
                         input logic [3:0] sf, input bit forbid, input bit prv);
        bit slot, e_v;
        logic [11:0] e_code;
        logic [PC_W-1:0] e_pc;
        instr_valid = v; opcode = op; pc = p; priv_mode = md; fpu_off = fd;
        slot_flags = sf; slot_forbid = forbid; priv_op = prv;
        slot = sf[0] | sf[1];
        e_v = 1'b1; e_code = held_code; e_pc = held_pc;
        if (!v) e_v = 1'b0;
        else if (forbid && slot) begin e_code = 12'h1A0; e_pc = p - 2; end
        else if (prv && !md)     begin e_code = 12'h180; e_pc = p; end
        else if (is_fpu_op(op) && fd) begin
            e_code = slot ? 12'h820 : 12'h800;
            e_pc   = slot ? p - 2 : p;
        end else e_v = 1'b0;
        @(negedge clk);
        check(req, exc_valid == e_v, "exc_valid", PC_W'(exc_valid), PC_W'(e_v));
        check(req, exc_code == e_code, "exc_code", PC_W'(exc_code), PC_W'(e_code));
        check(req, exc_pc == e_pc, "exc_pc", exc_pc, e_pc);
        held_code = e_code; held_pc = e_pc;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        held_code = '0; held_pc = '0;
        rst_n = 1'b0; instr_valid = 1'b0; opcode = '0; pc = '0; priv_mode = 1'b1;
        fpu_off = 1'b0; slot_flags = '0; slot_forbid = 1'b0; priv_op = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", exc_valid == 1'b0, "exc_valid", PC_W'(exc_valid), '0);
        check("R1", exc_code == '0, "exc_code", PC_W'(exc_code), '0);
        check("R1", exc_pc == '0, "exc_pc", exc_pc, '0);
        rst_n = 1'b1;
        apply("R1", 0, 16'h0009, 32'h100, 1, 0, 4'h0, 0, 0);

        apply("R2", 1, 16'h4A6A, 32'h1000, 1, 1, 4'h0, 0, 0);
        apply("R3", 1, 16'h035A, 32'h2004, 1, 1, 4'h1, 0, 0);
        apply("R3", 1, 16'h4F52, 32'h2010, 1, 1, 4'h2, 0, 0);
        apply("R4", 1, 16'h000B, 32'h3002, 1, 0, 4'h1, 1, 0);
        apply("R5", 1, 16'h0028, 32'h4000, 0, 0, 4'h0, 0, 1);
        apply("R6", 1, 16'h4066, 32'h5002, 0, 1, 4'h1, 1, 1);
        apply("R6", 1, 16'h4066, 32'h5100, 0, 1, 4'h0, 1, 1);
        apply("R6", 1, 16'h4066, 32'h5200, 1, 1, 4'h2, 1, 0);
        apply("R7", 1, 16'h406B, 32'h6000, 1, 1, 4'h0, 0, 0);
        apply("R7", 1, 16'h416A, 32'h6004, 1, 1, 4'h0, 0, 0);
        apply("R7", 1, 16'h4562, 32'h6008, 1, 0, 4'h1, 0, 0);
        apply("R8", 1, 16'h406A, 32'h7000, 1, 1, 4'hC, 0, 0);
        apply("R8", 1, 16'h000B, 32'h7004, 1, 0, 4'h4, 1, 0);
        apply("R9", 0, 16'h406A, 32'h8000, 0, 1, 4'h1, 1, 1);
        apply("R9", 1, 16'h406A, 32'h8010, 1, 1, 4'h0, 0, 0);
        apply("R9", 1, 16'h406A, 32'h8020, 1, 1, 4'h0, 0, 0);
        apply("R9", 1, 16'h0009, 32'h8030, 1, 1, 4'h0, 0, 0);
        apply("R10", 1, 16'h005A, 32'h0, 1, 1, 4'h1, 0, 0);
        apply("R10", 1, 16'h000B, 32'h1, 1, 0, 4'h2, 1, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] op;
            if ($urandom_range(1, 0) == 1) op = fpu_pick(int'($urandom_range(7, 0)), 4'($urandom));
            else op = 16'($urandom);
            apply("R6", ($urandom_range(7, 0) != 0), op, {$urandom, 1'b0} >> 1,
                  1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule